// File: doc/BRIEF.md
# Grouped Pin Toggle Interrupt Controller

This block watches a set of input pins, arranged in groups of up to eight, and raises one interrupt request per group when any pin that software has unmasked changes level. A change in either direction counts. Every group keeps a sticky flag. The flag stays set until one of two things happens: the processor takes that group's vector, shown here as a one-cycle acknowledge pulse, or software writes a one to the flag's bit. A request leaves the block only when three conditions hold together: the flag is set, the group's enable bit is set, and the global interrupt-enable input is high.

The default build has 27 pins in four groups. Pins 0 to 7 form group 0, pins 8 to 15 form group 1, pins 16 to 23 form group 2, and pins 24 to 26 form group 3, which is the short group. Each pin passes through a two-stage synchroniser. A third stage holds the last sampled level, and a change is the difference between that stage and the newest synchronised sample. Software reaches the block through a byte-wide port. The port has a 3-bit address, a write strobe and combinational read data. It holds the flag register, the group-enable register and one mask register per group.

Top module: `pin_toggle_irq`

## Requirements
- R1: Pin i belongs to group floor(i/8), so group 3 contains only pins 24, 25 and 26. A change on a pin sets only its own group's flag.
- R2: A rising or a falling change on an unmasked pin sets its group's flag. The flag reads as one no later than the third rising clock edge after the pin changes.
- R3: A change on a pin whose mask bit is 0 leaves its group's flag unchanged.
- R4: irq_o[g] is high exactly when flag g is 1, enable bit g is 1 and global_ie_i is 1.
- R5: A one on vec_ack_i[g] for one cycle clears flag g at the next clock edge. Other flags are not affected.
- R6: Writing to address 0 clears every flag whose bit in the write data is 1. Flags whose write-data bit is 0 keep their value.
- R7: The flag register (address 0) and the enable register (address 1) use only bits 3:0. Bits 7:4 always read 0, and writing them has no effect.
- R8: Each mask register (addresses 2 to 5 for groups 0 to 3) uses bit b for pin 8*g+b. The group 3 register keeps only bits 2:0, and bits 7:3 read 0.
- R9: After reset all flag, enable and mask registers read 0 and every irq_o is 0. Pin levels present during reset do not produce a change once reset is released.
- R10: If a qualified change arrives in the same cycle as an acknowledge or a write-one clear of the same flag, the flag ends up at 1.
- R11: Addresses 6 and 7 read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 27 | Asynchronous pins under watch |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| global_ie_i | input | 1 | Global interrupt enable |
| vec_ack_i | input | 4 | Per-group vector acknowledge, one cycle |
| irq_o | output | 4 | Per-group interrupt request |

## Verification
The assertions assume that reset is held low for at least two clock edges, so that the synchroniser and the previous-value stage are loaded before any property is evaluated. They also assume that acknowledge and write pulses last exactly one cycle. The stimulus drives every input at the falling edge. After each pin change it waits long enough for the change to pass the full synchroniser before the next operation starts. Only one directed case breaks that separation on purpose: it lines up an acknowledge and a write-one clear with the cycle in which a change is qualified, to check the priority rule.

// File: rtl/ptirq_pkg.sv
package ptirq_pkg;

  localparam int unsigned GRP_SPAN = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FLAG  = 3'd0,
    ADR_GEN   = 3'd1,
    ADR_MSK0  = 3'd2
  } reg_addr_e;

  // Number of pins that fall inside group grp for a block of npins pins.
  function automatic int unsigned pins_in_group(int unsigned grp, int unsigned npins);
    int unsigned lo;
    lo = grp * GRP_SPAN;
    if (npins <= lo) return 0;
    if (npins - lo >= GRP_SPAN) return GRP_SPAN;
    return npins - lo;
  endfunction

  // Address of the mask register belonging to group grp.
  function automatic logic [ADDR_W-1:0] mask_addr(int unsigned grp);
    return ADDR_W'(int'(ADR_MSK0) + int'(grp));
  endfunction

  // New flag value: events win over any clear source.
  function automatic logic flag_next(logic cur, logic evt, logic clr);
    return evt | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ptirq_sync_edge.sv
module ptirq_sync_edge #(
  parameter int unsigned NUM_PINS = 27
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] change_o
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // During reset every stage follows the pin, so release sees no edge.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= pins_i[i];
        sync_q <= pins_i[i];
        prev_q <= pins_i[i];
      end else begin
        meta_q <= pins_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign change_o[i] = sync_q ^ prev_q;
  end

endmodule

// File: rtl/ptirq_regs.sv
module ptirq_regs
  import ptirq_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 27,
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  we_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_GROUPS-1:0] flags_i,
  output logic [NUM_GROUPS-1:0] grp_en_o,
  output logic [NUM_PINS-1:0]   mask_o,
  output logic                  flag_wr_o,
  output logic [NUM_GROUPS-1:0] wclr_o,
  output logic [DATA_W-1:0]     rdata_o
);

  logic [NUM_GROUPS-1:0] en_q;
  logic [DATA_W-1:0]     mask_rd [NUM_GROUPS];

  assign flag_wr_o = we_i && (addr_i == ADR_FLAG);
  assign wclr_o    = flag_wr_o ? wdata_i[NUM_GROUPS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (we_i && (addr_i == ADR_GEN)) begin
      en_q <= wdata_i[NUM_GROUPS-1:0];
    end
  end

  assign grp_en_o = en_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
    localparam int unsigned LO  = g * GRP_SPAN;
    localparam int unsigned CNT = pins_in_group(g, NUM_PINS);
    localparam logic [ADDR_W-1:0] MY_ADDR = mask_addr(g);

    if (CNT > 0) begin : g_live
      logic [CNT-1:0] m_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          m_q <= '0;
        end else if (we_i && (addr_i == MY_ADDR)) begin
          m_q <= wdata_i[CNT-1:0];
        end
      end

      assign mask_o[LO +: CNT] = m_q;
      assign mask_rd[g]        = DATA_W'(m_q);
    end else begin : g_empty
      assign mask_rd[g] = '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_FLAG: rdata_o = DATA_W'(flags_i);
      ADR_GEN:  rdata_o = DATA_W'(en_q);
      default: begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (addr_i == mask_addr(g)) rdata_o = mask_rd[g];
        end
      end
    endcase
  end

endmodule

// File: rtl/ptirq_flags.sv
module ptirq_flags
  import ptirq_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] evt_i,
  input  logic [NUM_GROUPS-1:0] wclr_i,
  input  logic [NUM_GROUPS-1:0] ack_i,
  output logic [NUM_GROUPS-1:0] flags_o
);

  logic [NUM_GROUPS-1:0] flag_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else begin
        flag_q[g] <= flag_next(flag_q[g], evt_i[g], wclr_i[g] | ack_i[g]);
      end
    end
  end

  assign flags_o = flag_q;

endmodule

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq
  import ptirq_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 27,
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pins_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic                  global_ie_i,
  input  logic [NUM_GROUPS-1:0] vec_ack_i,
  output logic [NUM_GROUPS-1:0] irq_o
);

  // Named internal events, visible to the bound checker.
  logic [NUM_PINS-1:0]   pin_change;
  logic [NUM_PINS-1:0]   pin_mask;
  logic [NUM_PINS-1:0]   pin_qual;
  logic [NUM_GROUPS-1:0] grp_evt;
  logic [NUM_GROUPS-1:0] grp_en;
  logic [NUM_GROUPS-1:0] grp_flags;
  logic [NUM_GROUPS-1:0] grp_wclr;
  logic                  flag_wr;

  ptirq_sync_edge #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_i   (pins_i),
    .change_o (pin_change)
  );

  ptirq_regs #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (reg_addr_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .flags_i   (grp_flags),
    .grp_en_o  (grp_en),
    .mask_o    (pin_mask),
    .flag_wr_o (flag_wr),
    .wclr_o    (grp_wclr),
    .rdata_o   (reg_rdata_o)
  );

  assign pin_qual = pin_change & pin_mask;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int unsigned LO  = g * GRP_SPAN;
    localparam int unsigned CNT = pins_in_group(g, NUM_PINS);
    if (CNT > 0) begin : g_live
      assign grp_evt[g] = |pin_qual[LO +: CNT];
    end else begin : g_empty
      assign grp_evt[g] = 1'b0;
    end
  end

  ptirq_flags #(.NUM_GROUPS(NUM_GROUPS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (grp_evt),
    .wclr_i  (grp_wclr),
    .ack_i   (vec_ack_i),
    .flags_o (grp_flags)
  );

  assign irq_o = grp_flags & grp_en & {NUM_GROUPS{global_ie_i}};

endmodule

// File: rtl/ptirq_checker.sv
module ptirq_checker #(
  parameter int unsigned NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  global_ie_i,
  input logic [NUM_GROUPS-1:0] vec_ack_i,
  input logic [NUM_GROUPS-1:0] irq_o,
  input logic [NUM_GROUPS-1:0] evt,
  input logic [NUM_GROUPS-1:0] flags,
  input logic [NUM_GROUPS-1:0] grp_en,
  input logic [NUM_GROUPS-1:0] wclr,
  input logic                  flag_wr,
  input logic [2:0]            reg_addr_i,
  input logic [7:0]            reg_rdata_o
);

  assert_gate_global_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !global_ie_i |-> (irq_o == '0));

  assert_gate_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~grp_en) == '0);

  assert_need_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~flags) == '0);

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & (vec_ack_i | wclr))) |=>
      ((flags & $past(evt & (vec_ack_i | wclr))) == $past(evt & (vec_ack_i | wclr))));

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(vec_ack_i & ~evt)) |=> ((flags & $past(vec_ack_i & ~evt)) == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt == '0) && (vec_ack_i == '0) && !flag_wr) |=> $stable(flags));

  assert_flag_rsv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 3'd0) |-> ((reg_rdata_o >> NUM_GROUPS) == 8'd0));

  assert_flag_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 3'd0) |-> (reg_rdata_o[NUM_GROUPS-1:0] == flags));

endmodule

bind pin_toggle_irq ptirq_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .global_ie_i (global_ie_i),
  .vec_ack_i   (vec_ack_i),
  .irq_o       (irq_o),
  .evt         (grp_evt),
  .flags       (grp_flags),
  .grp_en      (grp_en),
  .wclr        (grp_wclr),
  .flag_wr     (flag_wr),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/pin_toggle_irq_bench.sv
`timescale 1ns/1ps
module pin_toggle_irq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [26:0] pins = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        gie = 1'b0;
  logic [3:0]  vec_ack = '0;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0]  exp_flags = '0;
  logic [3:0]  exp_en = '0;
  logic [26:0] exp_mask = '0;

  always #2.5 clk = ~clk;

  pin_toggle_irq u_pin_toggle_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .reg_addr_i  (reg_addr),
    .reg_we_i    (reg_we),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .global_ie_i (gie),
    .vec_ack_i   (vec_ack),
    .irq_o       (irq)
  );

  function automatic int grp_of(int pin);
    if (pin < 8)  return 0;
    if (pin < 16) return 1;
    if (pin < 24) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] mask_word(int g);
    logic [7:0] w = '0;
    for (int p = 0; p < 27; p++)
      if (grp_of(p) == g) w[p - 8*g] = exp_mask[p];
    return w;
  endfunction

  function automatic logic [3:0] exp_irq();
    return gie ? (exp_flags & exp_en) : 4'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_read(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic reg_write(logic [2:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
    if (a == 3'd0) exp_flags &= ~d[3:0];
    else if (a == 3'd1) exp_en = d[3:0];
    else if (a >= 3'd2 && a <= 3'd5)
      for (int p = 0; p < 27; p++)
        if (grp_of(p) == int'(a) - 2) exp_mask[p] = d[p - 8*(int'(a) - 2)];
  endtask

  task automatic set_pins(logic [26:0] nv);
    logic [26:0] diff = pins ^ nv;
    pins = nv;
    tick(4);
    for (int p = 0; p < 27; p++)
      if (diff[p] && exp_mask[p]) exp_flags[grp_of(p)] = 1'b1;
  endtask

  task automatic do_ack(logic [3:0] v);
    vec_ack = v;
    tick(1);
    vec_ack = '0;
    exp_flags &= ~v;
  endtask

  task automatic check_state(string req);
    logic [7:0] d;
    reg_read(3'd0, d);
    chk(req, {24'd0, d}, {28'd0, exp_flags});
    chk(req, {28'd0, irq}, {28'd0, exp_irq()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_0427));

    // R9: pins high during reset must not show up as a change afterwards
    pins = 27'h5A5_A5A5;
    tick(4);
    rst_n = 1'b1;
    gie = 1'b1;
    tick(5);
    chk("R9 irq", {28'd0, irq}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), d);
      chk("R9 reg", {24'd0, d}, 32'd0);
    end

    // R7 R8 R11: readback widths and unused addresses
    reg_write(3'd1, 8'hFF);
    reg_read(3'd1, d);  chk("R7 enable", {24'd0, d}, 32'h0F);
    reg_write(3'd5, 8'hFF);
    reg_read(3'd5, d);  chk("R8 mask3", {24'd0, d}, 32'h07);
    reg_write(3'd2, 8'hFF);
    reg_read(3'd2, d);  chk("R8 mask0", {24'd0, d}, 32'hFF);
    reg_write(3'd6, 8'hFF);
    reg_write(3'd7, 8'hFF);
    reg_read(3'd6, d);  chk("R11 addr6", {24'd0, d}, 32'd0);
    reg_read(3'd7, d);  chk("R11 addr7", {24'd0, d}, 32'd0);
    for (int a = 1; a < 6; a++) begin
      reg_read(3'(a), d);
      chk("R11 untouched", {24'd0, d},
          (a == 1) ? {28'd0, exp_en} : {24'd0, mask_word(a - 2)});
    end

    // R3: all masks clear, toggle everything
    for (int a = 2; a < 6; a++) reg_write(3'(a), 8'h00);
    set_pins(~pins);
    check_state("R3");

    // R1 R2: every pin alone, both directions
    for (int a = 2; a < 6; a++) reg_write(3'(a), 8'hFF);
    for (int p = 0; p < 27; p++) begin
      set_pins(pins ^ (27'd1 << p));
      chk("R1", {28'd0, exp_flags}, {28'd0, 4'(1 << grp_of(p))});
      check_state("R2");
      reg_write(3'd0, 8'h0F);
      check_state("R6");
    end

    // R3: masked neighbour in group 3, then unmasked pin
    reg_write(3'd5, 8'h02);
    set_pins(pins ^ 27'h100_0000);
    check_state("R3 pin24");
    set_pins(pins ^ 27'h200_0000);
    check_state("R2 pin25");

    // R5: acknowledge clears only its own group
    reg_write(3'd2, 8'h01);
    set_pins(pins ^ 27'h1);
    check_state("R2 g0");
    do_ack(4'b1000);
    check_state("R5");
    do_ack(4'b0001);
    check_state("R5");

    // R6 R7: zero writes and reserved bits leave flags alone
    set_pins(pins ^ 27'h1);
    set_pins(pins ^ 27'h200_0000);
    reg_write(3'd0, 8'h00);
    check_state("R6 zero");
    reg_write(3'd0, 8'hF0);
    check_state("R7 rsv");
    reg_write(3'd0, 8'h01);
    check_state("R6 one");

    // R4: gating by global and group enable
    gie = 1'b0; #1; check_state("R4 gie");
    gie = 1'b1; reg_write(3'd1, 8'h07); check_state("R4 en");
    reg_write(3'd1, 8'h0F); check_state("R4 on");
    reg_write(3'd0, 8'h0F);

    // R10: change qualified in the same cycle as ack and write-one clear
    pins = pins ^ 27'h1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    vec_ack = 4'b0001; reg_addr = 3'd0; reg_wdata = 8'h01; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    vec_ack = '0; reg_we = 1'b0;
    exp_flags[0] = 1'b1;
    check_state("R10");
    tick(3);
    check_state("R10 hold");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0, 1: set_pins(pins ^ (27'($urandom) & 27'($urandom) & 27'($urandom)));
        2: begin
          int a = $urandom_range(2, 5);
          reg_write(3'(a), 8'($urandom));
          reg_read(3'(a), d);
          chk("R8 rand", {24'd0, d}, {24'd0, mask_word(a - 2)});
        end
        3: reg_write(3'd1, 8'($urandom));
        4: reg_write(3'd0, 8'($urandom));
        default: begin
          if ($urandom_range(0, 3) == 0) begin gie = ~gie; #1; end
          else do_ack(4'($urandom));
        end
      endcase
      check_state("R4 rand");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule